// File: doc/BRIEF.md
# Compute Unit Operand and Result Handshake Controller

This block is the control logic for one compute unit of an out-of-order core. A single issue pulse hands the unit a new operation. Each source operand then raises its own read request and waits for its own read grant. An operand marked as an immediate takes its value at issue and never asks for a read port. Once every operand is held locally, a stub execution stage with a fixed, parameterised latency produces the results. Each result is kept in its own latch and raises its own write request, so results bound for different register files are granted independently.

The unit's position in the array of compute units is its rename tag, so no tag is stored. Two inputs can hold back or throw away the operation at any time. A shadow input holds off every write request while some earlier condition is still unresolved. A cancel input returns the unit to idle at once, drops every request and discards any partial or held result. A busy output tells the issue logic when the unit can accept new work.

Top module: `fu_opctl`

## Requirements
- R1: An issue pulse seen while busy_o is low starts an operation: busy_o is high after that edge and rd_req_o bit i is high exactly when src_valid_i bit i was 1. An issue pulse seen while busy_o is high is ignored: no request changes and the held results are unchanged.
- R2: An operand whose src_valid_i bit is 0 takes its value from slot i of imm_i (bits i*DW and up) at the issue edge. A go_rd_i bit for an operand that is not requesting is ignored, and so is the imm_i slot of an operand that is read from a register.
- R3: go_rd_i bit i seen while rd_req_o bit i is high captures slot i of rd_data_i at that edge, and rd_req_o bit i is low after that edge.
- R4: The write requests rise LAT+1 clock edges after the edge that captured the last register operand, or after the issue edge when there is none. Even-numbered results (slot 0 of wr_data_o) hold the sum of all operands modulo 2^DW, and odd-numbered results (slot 1) hold their bitwise XOR.
- R5: While shadow_i is high every wr_req_o bit is low and go_wr_i is ignored. When shadow_i falls while a result is held, the write requests rise in that same cycle.
- R6: go_wr_i bit j seen while wr_req_o bit j is high retires only result j: its request is low after that edge, the other requests stay high, and unretired result data stays unchanged.
- R7: busy_o goes low after the edge on which the last outstanding result is granted, and not before.
- R8: While go_die_i is high every rd_req_o and wr_req_o bit is low in that same cycle. After that edge the unit is idle, and the cancelled operation never raises a write request.
- R9: When go_die_i and go_wr_i are high in the same cycle, cancellation wins: wr_req_o is low in that cycle, so the write is not accepted, and the unit is idle after the edge.
- R10: After reset busy_o, rd_req_o and wr_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | One-cycle pulse that starts an operation |
| src_valid_i | input | NSRC | Per operand: 1 means read from a register, 0 means immediate |
| imm_i | input | NSRC*DW | Immediate values, slot i for operand i, captured at issue |
| rd_req_o | output | NSRC | Per operand read request |
| go_rd_i | input | NSRC | Per operand read grant |
| rd_data_i | input | NSRC*DW | Read data, slot i for operand i, valid with its grant |
| shadow_i | input | 1 | Holds off all write requests while high |
| go_die_i | input | 1 | Cancels the operation and returns the unit to idle |
| wr_req_o | output | NDST | Per result write request |
| go_wr_i | input | NDST | Per result write grant |
| wr_data_o | output | NDST*DW | Held result data, slot j for result j |
| busy_o | output | 1 | High from issue until the last write grant or cancellation |

## Verification
The hardest situation to reach is cancellation coinciding with a write grant while a result is held, since it needs the operation to have run to completion with both results still outstanding, and then a grant and a cancel on the same edge. The stimulus runs an all-immediate operation to its held state, then raises both grants together with the cancel and checks that no request was visible in that cycle and that the unit is idle afterwards. Cancellation during the read phase and in the middle of the execution count is reached the same way, followed by a fresh operation to show no stale result leaks out. Shadow release is checked within the cycle it falls, between clock edges, to show the request rises without a registered delay.

// File: rtl/fu_opctl_pkg.sv
package fu_opctl_pkg;

    // Life cycle of the one operation the unit can hold.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_READ = 2'd1,
        PH_EXEC = 2'd2,
        PH_HOLD = 2'd3
    } fu_phase_e;

    // Which combination the stub execution stage produces for a result.
    typedef enum logic {
        RES_SUM = 1'b0,
        RES_XOR = 1'b1
    } res_kind_e;

    function automatic res_kind_e kind_of(input int unsigned idx);
        return (idx % 2 == 0) ? RES_SUM : RES_XOR;
    endfunction

    // Next phase; cancellation overrides every other event.
    function automatic fu_phase_e phase_step(
        input fu_phase_e cur,
        input logic      kill,
        input logic      issue,
        input logic      reads_left,
        input logic      res_fire,
        input logic      last_write
    );
        fu_phase_e nxt;
        nxt = cur;
        if (kill) begin
            nxt = PH_IDLE;
        end else begin
            case (cur)
                PH_IDLE: if (issue)       nxt = PH_READ;
                PH_READ: if (!reads_left) nxt = PH_EXEC;
                PH_EXEC: if (res_fire)    nxt = PH_HOLD;
                PH_HOLD: if (last_write)  nxt = PH_IDLE;
                default:                  nxt = PH_IDLE;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/fu_src_slot.sv
module fu_src_slot #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kill,
    input  logic          take,
    input  logic          need_rd,
    input  logic [DW-1:0] imm,
    input  logic          go_rd,
    input  logic [DW-1:0] rd_data,
    output logic          req_q,
    output logic [DW-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            data_q <= '0;
        end else if (kill) begin
            req_q  <= 1'b0;
        end else if (take) begin
            req_q  <= need_rd;
            if (!need_rd) begin
                data_q <= imm;
            end
        end else if (req_q && go_rd) begin
            req_q  <= 1'b0;
            data_q <= rd_data;
        end
    end

    // R3: a granted read retires its request on the same edge
    a_r3_req_clears: assert property (@(posedge clk) disable iff (rst)
        req_q && go_rd && !kill |=> !req_q);

    // R2: a grant with no request pending leaves the operand alone
    a_r2_idle_grant_ignored: assert property (@(posedge clk) disable iff (rst)
        !req_q && !take |=> $stable(data_q));

endmodule

// File: rtl/fu_dst_slot.sv
module fu_dst_slot #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kill,
    input  logic          load,
    input  logic [DW-1:0] res_in,
    input  logic          shadow,
    input  logic          go_wr,
    output logic          wr_req,
    output logic [DW-1:0] data_q,
    output logic          pend_q
);

    // Shadow gating is combinational so a release shows in the same cycle.
    assign wr_req = pend_q && !shadow && !kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            data_q <= '0;
        end else if (kill) begin
            pend_q <= 1'b0;
        end else if (load) begin
            pend_q <= 1'b1;
            data_q <= res_in;
        end else if (wr_req && go_wr) begin
            pend_q <= 1'b0;
        end
    end

    // R6: an accepted grant retires exactly this result
    a_r6_grant_retires: assert property (@(posedge clk) disable iff (rst)
        wr_req && go_wr |=> !pend_q);

    // R6: held data does not move while waiting for the port
    a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
        pend_q && !load |=> $stable(data_q));

endmodule

// File: rtl/fu_exec_stub.sv
module fu_exec_stub
    import fu_opctl_pkg::*;
#(
    parameter int unsigned NSRC = 3,
    parameter int unsigned NDST = 2,
    parameter int unsigned DW   = 16,
    parameter int unsigned LAT  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 kill,
    input  logic                 start,
    input  logic [NSRC*DW-1:0]   ops,
    output logic                 res_fire,
    output logic [NDST*DW-1:0]   res
);

    localparam int unsigned CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] sum_w;
    logic [DW-1:0] xor_w;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(LAT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign res_fire = (cnt_q == CW'(1)) && !kill;

    always_comb begin
        sum_w = '0;
        xor_w = '0;
        for (int i = 0; i < NSRC; i++) begin
            sum_w = sum_w + ops[i*DW +: DW];
            xor_w = xor_w ^ ops[i*DW +: DW];
        end
    end

    for (genvar j = 0; j < NDST; j++) begin : g_res
        localparam res_kind_e KIND = kind_of(j);
        if (KIND == RES_SUM) begin : g_sum
            assign res[j*DW +: DW] = sum_w;
        end else begin : g_xor
            assign res[j*DW +: DW] = xor_w;
        end
    end

    // R4: no new count starts while one is running
    a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
        cnt_q != '0 |-> !start);

endmodule

// File: rtl/fu_opctl.sv
module fu_opctl
    import fu_opctl_pkg::*;
#(
    parameter int unsigned NSRC = 3,
    parameter int unsigned NDST = 2,
    parameter int unsigned DW   = 16,
    parameter int unsigned LAT  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_i,
    input  logic [NSRC-1:0]      src_valid_i,
    input  logic [NSRC*DW-1:0]   imm_i,
    output logic [NSRC-1:0]      rd_req_o,
    input  logic [NSRC-1:0]      go_rd_i,
    input  logic [NSRC*DW-1:0]   rd_data_i,
    input  logic                 shadow_i,
    input  logic                 go_die_i,
    output logic [NDST-1:0]      wr_req_o,
    input  logic [NDST-1:0]      go_wr_i,
    output logic [NDST*DW-1:0]   wr_data_o,
    output logic                 busy_o
);

    fu_phase_e            phase_q;
    logic                 take;
    logic                 reads_left;
    logic                 start;
    logic                 res_fire;
    logic                 load;
    logic                 last_write;
    logic [NSRC-1:0]      rd_req_q;
    logic [NSRC*DW-1:0]   ops;
    logic [NDST*DW-1:0]   res;
    logic [NDST-1:0]      pend_q;

    assign take       = issue_i && (phase_q == PH_IDLE) && !go_die_i;
    assign reads_left = |rd_req_q;
    assign start      = (phase_q == PH_READ) && !reads_left;
    assign load       = (phase_q == PH_EXEC) && res_fire;
    assign last_write = (phase_q == PH_HOLD) && ((pend_q & ~(wr_req_o & go_wr_i)) == '0);
    assign busy_o     = (phase_q != PH_IDLE);
    assign rd_req_o   = rd_req_q & ~{NSRC{go_die_i}};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_step(phase_q, go_die_i, issue_i, reads_left, res_fire, last_write);
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        fu_src_slot #(.DW(DW)) u_src (
            .clk     (clk),
            .rst     (rst),
            .kill    (go_die_i),
            .take    (take),
            .need_rd (src_valid_i[i]),
            .imm     (imm_i[i*DW +: DW]),
            .go_rd   (go_rd_i[i]),
            .rd_data (rd_data_i[i*DW +: DW]),
            .req_q   (rd_req_q[i]),
            .data_q  (ops[i*DW +: DW])
        );
    end

    fu_exec_stub #(.NSRC(NSRC), .NDST(NDST), .DW(DW), .LAT(LAT)) u_exec (
        .clk      (clk),
        .rst      (rst),
        .kill     (go_die_i),
        .start    (start),
        .ops      (ops),
        .res_fire (res_fire),
        .res      (res)
    );

    for (genvar j = 0; j < NDST; j++) begin : g_dst
        fu_dst_slot #(.DW(DW)) u_dst (
            .clk    (clk),
            .rst    (rst),
            .kill   (go_die_i),
            .load   (load),
            .res_in (res[j*DW +: DW]),
            .shadow (shadow_i),
            .go_wr  (go_wr_i[j]),
            .wr_req (wr_req_o[j]),
            .data_q (wr_data_o[j*DW +: DW]),
            .pend_q (pend_q[j])
        );
    end

    // R1: an issue to an idle unit makes it busy
    a_r1_issue_takes: assert property (@(posedge clk) disable iff (rst)
        issue_i && !busy_o && !go_die_i |=> busy_o);

    // R8: cancellation leaves the unit idle
    a_r8_die_idles: assert property (@(posedge clk) disable iff (rst)
        go_die_i |=> !busy_o);

    // R7: busy only drops through a cancel or an accepted write grant
    a_r7_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(go_die_i) || $past(|(go_wr_i & wr_req_o)));

    // R4: write requests only appear once a result is held
    a_r4_req_in_hold: assert property (@(posedge clk) disable iff (rst)
        |wr_req_o |-> phase_q == PH_HOLD);

    // R3: no read requests remain once execution has begun
    a_r3_reads_done: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_EXEC |-> rd_req_q == '0);

endmodule

// File: tb/tb_fu_opctl.sv
module tb_fu_opctl;

    localparam int NSRC = 3;
    localparam int NDST = 2;
    localparam int DW   = 16;
    localparam int LAT  = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                issue_i = 1'b0;
    logic [NSRC-1:0]     src_valid_i = '0;
    logic [NSRC*DW-1:0]  imm_i = '0;
    logic [NSRC-1:0]     rd_req_o;
    logic [NSRC-1:0]     go_rd_i = '0;
    logic [NSRC*DW-1:0]  rd_data_i = '0;
    logic                shadow_i = 1'b0;
    logic                go_die_i = 1'b0;
    logic [NDST-1:0]     wr_req_o;
    logic [NDST-1:0]     go_wr_i = '0;
    logic [NDST*DW-1:0]  wr_data_o;
    logic                busy_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    fu_opctl #(.NSRC(NSRC), .NDST(NDST), .DW(DW), .LAT(LAT)) dut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .src_valid_i(src_valid_i),
        .imm_i(imm_i), .rd_req_o(rd_req_o), .go_rd_i(go_rd_i),
        .rd_data_i(rd_data_i), .shadow_i(shadow_i), .go_die_i(go_die_i),
        .wr_req_o(wr_req_o), .go_wr_i(go_wr_i), .wr_data_o(wr_data_o),
        .busy_o(busy_o)
    );

    typedef struct packed {
        logic [2:0]  mask;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
        logic [3:0]  gap;
        logic        rev;
        logic        shd;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{3'b111, 16'h0001, 16'h0002, 16'h0003, 4'd0, 1'b0, 1'b0},
        '{3'b000, 16'h1234, 16'h00FF, 16'hF0F0, 4'd0, 1'b0, 1'b0},
        '{3'b101, 16'hFFFF, 16'h0010, 16'h0002, 4'd2, 1'b0, 1'b0},
        '{3'b111, 16'h8000, 16'h8000, 16'h0001, 4'd1, 1'b1, 1'b0},
        '{3'b010, 16'h0A0A, 16'h5050, 16'h0303, 4'd3, 1'b0, 1'b1},
        '{3'b110, 16'h7777, 16'h1111, 16'h2222, 4'd0, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] opv(input vec_t v, input int i);
        return (i == 0) ? v.a : (i == 1) ? v.b : v.c;
    endfunction

    task automatic wait_wr(output int n);
        n = 0;
        while (wr_req_o == '0 && n < 50) begin
            tick();
            n++;
        end
    endtask

    task automatic issue_op(input logic [2:0] mask, input logic [15:0] a,
                            input logic [15:0] b, input logic [15:0] c);
        src_valid_i = mask;
        imm_i = {c, b, a};
        issue_i = 1'b1;
        tick();
        issue_i = 1'b0;
    endtask

    task automatic grant_both();
        go_wr_i = 2'b11;
        tick();
        go_wr_i = 2'b00;
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        logic [15:0] s;
        logic [15:0] x;
        s = v.a + v.b + v.c;
        x = v.a ^ v.b ^ v.c;
        src_valid_i = v.mask;
        for (int i = 0; i < NSRC; i++)
            imm_i[i*DW +: DW] = v.mask[i] ? 16'hBEEF : opv(v, i);
        issue_i = 1'b1;
        tick();
        issue_i = 1'b0;
        chk("R1 busy after issue", {31'd0, busy_o}, 32'd1);
        chk("R1 read requests follow valid mask", {29'd0, rd_req_o}, {29'd0, v.mask});
        for (int k = 0; k < NSRC; k++) begin
            int i;
            i = v.rev ? (NSRC - 1 - k) : k;
            if (v.mask[i]) begin
                repeat (int'(v.gap)) tick();
                go_rd_i[i] = 1'b1;
                rd_data_i[i*DW +: DW] = opv(v, i);
                tick();
                go_rd_i = '0;
                rd_data_i = '0;
                chk("R3 read request cleared after grant", {31'd0, rd_req_o[i]}, 32'd0);
            end
        end
        if (v.shd) begin
            shadow_i = 1'b1;
            repeat (LAT + 3) tick();
            chk("R5 no write request under shadow", {30'd0, wr_req_o}, 32'd0);
            chk("R7 busy while shadowed", {31'd0, busy_o}, 32'd1);
            shadow_i = 1'b0;
            #1;
            chk("R5 request rises in release cycle", {30'd0, wr_req_o}, 32'd3);
        end else begin
            wait_wr(n);
            chk("R4 result latency", n, LAT + 1);
            chk("R6 both results request", {30'd0, wr_req_o}, 32'd3);
        end
        chk("R4 sum result", {16'd0, wr_data_o[15:0]}, {16'd0, s});
        chk("R4 xor result", {16'd0, wr_data_o[31:16]}, {16'd0, x});
        go_wr_i = 2'b01;
        tick();
        go_wr_i = 2'b00;
        chk("R6 only result 0 retired", {30'd0, wr_req_o}, 32'd2);
        chk("R7 busy with one result left", {31'd0, busy_o}, 32'd1);
        chk("R6 result 1 data held", {16'd0, wr_data_o[31:16]}, {16'd0, x});
        go_wr_i = 2'b10;
        tick();
        go_wr_i = 2'b00;
        chk("R7 idle after last grant", {31'd0, busy_o}, 32'd0);
        chk("R6 no requests after both grants", {30'd0, wr_req_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy after reset", {31'd0, busy_o}, 32'd0);
        chk("R10 read requests after reset", {29'd0, rd_req_o}, 32'd0);
        chk("R10 write requests after reset", {30'd0, wr_req_o}, 32'd0);

        for (int t = 0; t < 6; t++) run_vec(VECS[t]);

        // R2: grant to an immediate operand is ignored
        issue_op(3'b110, 16'd5, 16'hAAAA, 16'hAAAA);
        go_rd_i = 3'b001;
        rd_data_i = {16'd0, 16'd0, 16'h0077};
        tick();
        go_rd_i = '0;
        chk("R2 requests unchanged by stray grant", {29'd0, rd_req_o}, 32'd6);
        go_rd_i = 3'b110;
        rd_data_i = {16'd2, 16'd1, 16'h0099};
        tick();
        go_rd_i = '0;
        rd_data_i = '0;
        wait_wr(n);
        chk("R2 immediate kept in sum", {16'd0, wr_data_o[15:0]}, 32'd8);
        chk("R2 immediate kept in xor", {16'd0, wr_data_o[31:16]}, 32'd6);
        grant_both();
        chk("R6 simultaneous grants retire both", {31'd0, busy_o}, 32'd0);

        // R1: issue while busy is ignored
        issue_op(3'b000, 16'd1, 16'd2, 16'd3);
        wait_wr(n);
        issue_op(3'b111, 16'd9, 16'd9, 16'd9);
        chk("R1 no reads from ignored issue", {29'd0, rd_req_o}, 32'd0);
        chk("R1 held result unchanged", {16'd0, wr_data_o[15:0]}, 32'd6);
        grant_both();

        // R5: grants under shadow are ignored
        issue_op(3'b000, 16'd1, 16'd1, 16'd1);
        shadow_i = 1'b1;
        repeat (LAT + 3) tick();
        go_wr_i = 2'b11;
        tick();
        go_wr_i = 2'b00;
        shadow_i = 1'b0;
        #1;
        chk("R5 shadowed grant not accepted", {30'd0, wr_req_o}, 32'd3);
        @(negedge clk);
        grant_both();

        // R8: cancel during reads
        issue_op(3'b111, 16'd0, 16'd0, 16'd0);
        go_rd_i = 3'b001;
        rd_data_i = {16'd0, 16'd0, 16'd4};
        tick();
        go_rd_i = '0;
        go_die_i = 1'b1;
        #1;
        chk("R8 read requests drop at once", {29'd0, rd_req_o}, 32'd0);
        @(negedge clk);
        go_die_i = 1'b0;
        chk("R8 idle after cancel in read", {31'd0, busy_o}, 32'd0);
        repeat (LAT + 3) tick();
        chk("R8 no write after cancel in read", {30'd0, wr_req_o}, 32'd0);

        // R8: cancel while executing
        issue_op(3'b000, 16'd7, 16'd7, 16'd7);
        tick();
        tick();
        go_die_i = 1'b1;
        tick();
        go_die_i = 1'b0;
        chk("R8 idle after cancel in exec", {31'd0, busy_o}, 32'd0);
        repeat (LAT + 3) tick();
        chk("R8 partial result discarded", {30'd0, wr_req_o}, 32'd0);
        issue_op(3'b000, 16'd4, 16'd5, 16'd6);
        wait_wr(n);
        chk("R8 fresh operation latency", n, LAT + 1);
        chk("R8 fresh operation result", {16'd0, wr_data_o[15:0]}, 32'd15);

        // R9: cancel beats write grant
        go_wr_i = 2'b11;
        go_die_i = 1'b1;
        #1;
        chk("R9 no request under cancel", {30'd0, wr_req_o}, 32'd0);
        @(negedge clk);
        go_wr_i = 2'b00;
        go_die_i = 1'b0;
        chk("R9 idle after cancel with grant", {31'd0, busy_o}, 32'd0);
        chk("R9 no request after cancel", {30'd0, wr_req_o}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule